// File: doc/BRIEF.md
# Infrared Transceiver Mode Controller

This block is the digital control core of an infrared transceiver whose single LED driver is shared by two kinds of traffic: IrDA data and remote-control (RC) bursts. It watches a shutdown line and two transmit lines, all sampled on a fast system clock. From them it decides the operating mode and drives two LED enables, a receiver bandwidth select and the enable of the receive-data output driver.

The shutdown line also carries a small serial protocol. A short high pulse on it is a programming pulse. On its falling edge the controller captures the level of the IrDA transmit line: a high level selects the wide MIR/FIR bandwidth and a low level selects SIR. If the IrDA line pulsed high and returned low while the shutdown line was high, the controller switches to single-input RC mode, in which the IrDA line steers the RC LED path. A long high pulse is a full shutdown. It turns the receive output driver off and returns the controller to its power-up default of SIR bandwidth with direct two-input drive. Each LED path has its own stuck-on timer. The timer cuts the LED if its drive source stays high too long and keeps it off until that source falls.

All inputs are assumed to be synchronous to `clk`. Outputs are registered, so every output answers its inputs one clock later.

Top module: `irx_mode_ctrl`

## Requirements
- R1: After reset, `bwHigh`=0 (SIR), `rcModeOn`=0 (direct mode), `irLedEn`=0, `rcLedEn`=0 and `rxDrvEn`=1.
- R2: When `sdIn` is sampled low after one or more high samples that did not reach shutdown, and `txIrIn` is high in that same sample, `bwHigh` becomes 1 one cycle later and `rcModeOn` becomes 0. `bwHigh` changes at no other time except on entry to shutdown.
- R3: A programming pulse that ends with `txIrIn` low, and during which `txIrIn` never fell, sets `bwHigh` to 0 and `rcModeOn` to 0.
- R4: After `SHUT_CYCLES` consecutive high samples of `sdIn`, `rxDrvEn` is 0 in the following cycle. A pulse of `SHUT_CYCLES-1` samples is treated as programming and leaves `rxDrvEn` at 1.
- R5: Entering shutdown forces `bwHigh`=0 and `rcModeOn`=0. Leaving shutdown captures nothing, so both stay 0 whatever the level of `txIrIn`.
- R6: In the cycle after any sample with `sdIn` high, `irLedEn` and `rcLedEn` are both 0.
- R7: In direct mode with `sdIn` low, `irLedEn` follows `txIrIn` and `rcLedEn` follows `txRcIn`, each one cycle later.
- R8: A programming pulse during which `txIrIn` rose and fell, and which ends with `txIrIn` low, sets `rcModeOn`=1 and `bwHigh`=0. In that mode `txIrIn` drives `rcLedEn`, `irLedEn` stays 0 and `txRcIn` has no effect.
- R9: An LED enable stays high for at most `STUCK_CYCLES` consecutive cycles while its drive source is held high. It then stays 0 until the source has been sampled low, after which it can turn on again.
- R10: The two stuck-on timers are independent: a timed-out IR path does not stop `rcLedEn` from following its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sdIn | input | 1 | Shutdown / programming line, active high |
| txIrIn | input | 1 | IrDA transmit data; the RC drive source in single-input mode |
| txRcIn | input | 1 | RC transmit data in direct mode |
| irLedEn | output | 1 | Enable for the IrDA LED current path |
| rcLedEn | output | 1 | Enable for the RC LED current path |
| bwHigh | output | 1 | Receiver bandwidth: 1 = MIR/FIR, 0 = SIR |
| rcModeOn | output | 1 | 1 when single-input RC mode is active |
| rxDrvEn | output | 1 | Receive-data output driver enable; 0 means high impedance |

## Verification
On every cycle the assertions check four things: the LEDs are quiet after any shutdown-line high sample; the receive driver turns off only after the shutdown line has been high; the bandwidth select moves only on a programming falling edge or on entry to shutdown; and shutdown leaves the default modes in place. They also check that the IR LED never lights in RC mode and that no LED enable stays high longer than the stuck-on limit. Only the bench scenarios can show the values that get captured: MIR/FIR versus SIR versus RC selection from the shape of the TxIR activity, the exact pulse length that separates programming from shutdown, the re-arming of a timed-out path, and the independence of the two timers.

// File: rtl/irx_pkg.sv
package irx_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PROG = 2'd1,
    ST_SHUT = 2'd2
  } modeState_t;

  // strobes from the sequencing control to the mode/LED datapath
  typedef struct packed {
    logic txAllowed;  // normal transmit permitted this cycle
    logic progStart;  // first shutdown-line high sample
    logic progWin;    // inside a programming pulse
    logic latchBw;    // programming pulse ends this sample
    logic shutEnter;  // pulse has become a full shutdown
  } ctrlStrobe_t;

endpackage

// File: rtl/irx_ctrl.sv
module irx_ctrl
  import irx_pkg::*;
#(
  parameter int SHUT_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdIn,
  output ctrlStrobe_t strobe,
  output logic        rxDrvEn
);

  localparam int CW = $clog2(SHUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST_PROG = CW'(SHUT_CYCLES - 1);

  modeState_t state, stateNext;
  logic [CW-1:0] sdCnt;

  always_comb begin
    strobe.txAllowed = (state == ST_RUN) && !sdIn;
    strobe.progStart = (state == ST_RUN) && sdIn;
    strobe.progWin   = (state == ST_PROG);
    strobe.latchBw   = (state == ST_PROG) && !sdIn;
    strobe.shutEnter = (state == ST_PROG) && sdIn && (sdCnt == LAST_PROG);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  if (sdIn) stateNext = (SHUT_CYCLES <= 1) ? ST_SHUT : ST_PROG;
      ST_PROG: begin
        if (!sdIn)                 stateNext = ST_RUN;
        else if (strobe.shutEnter) stateNext = ST_SHUT;
      end
      ST_SHUT: if (!sdIn) stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      sdCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.progStart)               sdCnt <= CW'(1);
      else if (strobe.progWin && sdIn)    sdCnt <= sdCnt + CW'(1);
      else if (!sdIn)                     sdCnt <= '0;
    end
  end

  assign rxDrvEn = (state != ST_SHUT);

  // R4: a programming pulse is never longer than the threshold
  p_prog_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> (sdCnt <= LAST_PROG));

endmodule

// File: rtl/irx_datapath.sv
module irx_datapath
  import irx_pkg::*;
#(
  parameter int STUCK_CYCLES = 10_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        txIrIn,
  input  logic        txRcIn,
  output logic        irLedEn,
  output logic        rcLedEn,
  output logic        bwHigh,
  output logic        rcModeOn
);

  localparam int NPATH = 2;
  localparam int TW    = $clog2(STUCK_CYCLES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(STUCK_CYCLES);

  logic txIrQ, pulseSeen;
  logic [NPATH-1:0] src, ledQ;

  // TxIR fall inside the programming window marks an RC-select pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrQ     <= 1'b0;
      pulseSeen <= 1'b0;
      bwHigh    <= 1'b0;
      rcModeOn  <= 1'b0;
    end else begin
      txIrQ <= txIrIn;
      if (strobe.progStart)                         pulseSeen <= 1'b0;
      else if (strobe.progWin && txIrQ && !txIrIn)  pulseSeen <= 1'b1;
      if (strobe.shutEnter) begin
        bwHigh   <= 1'b0;
        rcModeOn <= 1'b0;
      end else if (strobe.latchBw) begin
        bwHigh   <= txIrIn;
        rcModeOn <= !txIrIn && pulseSeen;
      end
    end
  end

  assign src[0] = strobe.txAllowed && !rcModeOn && txIrIn;
  assign src[1] = strobe.txAllowed && (rcModeOn ? txIrIn : txRcIn);

  // one stuck-on timer per LED path
  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic [TW-1:0] onCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        onCnt   <= '0;
        ledQ[g] <= 1'b0;
      end else if (src[g]) begin
        ledQ[g] <= (onCnt < LIMIT);
        if (onCnt < LIMIT) onCnt <= onCnt + TW'(1);
      end else begin
        ledQ[g] <= 1'b0;
        onCnt   <= '0;
      end
    end
  end

  assign irLedEn = ledQ[0];
  assign rcLedEn = ledQ[1];

  // R8: the IR path is silent in single-input RC mode
  p_rc_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    rcModeOn |-> !irLedEn);

endmodule

// File: rtl/irx_mode_ctrl.sv
module irx_mode_ctrl
  import irx_pkg::*;
#(
  parameter int SHUT_CYCLES  = 1000,
  parameter int STUCK_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdIn,
  input  logic txIrIn,
  input  logic txRcIn,
  output logic irLedEn,
  output logic rcLedEn,
  output logic bwHigh,
  output logic rcModeOn,
  output logic rxDrvEn
);

  ctrlStrobe_t strobe;

  irx_ctrl #(.SHUT_CYCLES(SHUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .strobe(strobe), .rxDrvEn(rxDrvEn)
  );

  irx_datapath #(.STUCK_CYCLES(STUCK_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txIrIn(txIrIn), .txRcIn(txRcIn),
    .irLedEn(irLedEn), .rcLedEn(rcLedEn), .bwHigh(bwHigh), .rcModeOn(rcModeOn)
  );

  // checker-side run-length counters for the stuck-on limit
  localparam int RW = $clog2(STUCK_CYCLES + 2);
  logic [RW-1:0] runIr, runRc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runIr <= '0;
      runRc <= '0;
    end else begin
      runIr <= irLedEn ? ((runIr < RW'(STUCK_CYCLES)) ? runIr + RW'(1) : runIr) : '0;
      runRc <= rcLedEn ? ((runRc < RW'(STUCK_CYCLES)) ? runRc + RW'(1) : runRc) : '0;
    end
  end

  p_led_run_limit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irLedEn |-> runIr < RW'(STUCK_CYCLES)) and (rcLedEn |-> runRc < RW'(STUCK_CYCLES)));

  p_sd_quiets_leds_r6: assert property (@(posedge clk) disable iff (!rstN)
    sdIn |=> (!irLedEn && !rcLedEn));

  p_rx_off_needs_sd_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDrvEn) |-> $past(sdIn));

  p_shut_defaults_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rxDrvEn |-> (!bwHigh && !rcModeOn));

  p_bw_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bwHigh != $past(bwHigh)) |-> (!rxDrvEn || ($past(sdIn, 2) && !$past(sdIn))));

endmodule

// File: tb/irx_mode_ctrl_tb.sv
`timescale 1ns/1ps
module irx_mode_ctrl_tb;

  localparam int SHUT  = 40;
  localparam int STUCK = 100;

  logic clk = 1'b0, rstN = 1'b0;
  logic sdIn = 1'b0, txIrIn = 1'b0, txRcIn = 1'b0;
  logic irLedEn, rcLedEn, bwHigh, rcModeOn, rxDrvEn;

  always #2.5 clk = ~clk;

  irx_mode_ctrl #(.SHUT_CYCLES(SHUT), .STUCK_CYCLES(STUCK)) u_dut (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .txIrIn(txIrIn), .txRcIn(txRcIn),
    .irLedEn(irLedEn), .rcLedEn(rcLedEn), .bwHigh(bwHigh), .rcModeOn(rcModeOn),
    .rxDrvEn(rxDrvEn)
  );

  typedef struct { logic [4:0] v; string tag; } expItem_t;
  expItem_t sbQ[$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  // advance n edges, land 1 ns after the last one
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver side: push expected {ir, rc, bw, rcMode, rxEn}
  task automatic expect5(logic ir, logic rc, logic bw, logic rcm, logic rx, string tag);
    expItem_t it;
    it.v = {ir, rc, bw, rcm, rx};
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor side: compare as soon as an expectation is queued
  initial begin
    forever begin
      expItem_t it;
      logic [4:0] act;
      wait (sbQ.size() != 0);
      it = sbQ.pop_front();
      act = {irLedEn, rcLedEn, bwHigh, rcModeOn, rxDrvEn};
      nChecks++;
      if (act !== it.v) begin
        nFails++;
        $display("FAIL %s: {ir,rc,bw,rcm,rx} actual %b expected %b", it.tag, act, it.v);
      end
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expect5(0,0,0,0,1, "R1 reset defaults");

    // direct two-input drive
    txIrIn = 1; tick(1); expect5(1,0,0,0,1, "R7 TxIR drives IR LED");
    txIrIn = 0; txRcIn = 1; tick(1); expect5(0,1,0,0,1, "R7 TxRC drives RC LED");
    txRcIn = 0; tick(1); expect5(0,0,0,0,1, "R7 both low idle");

    // program MIR/FIR
    sdIn = 1; tick(1); expect5(0,0,0,0,1, "R6 SD high leds off");
    txIrIn = 1; tick(3); expect5(0,0,0,0,1, "R6 TxIR ignored while SD high");
    sdIn = 0; tick(1); expect5(0,0,1,0,1, "R2 fall latches MIR/FIR");
    tick(1); expect5(1,0,1,0,1, "R7 IR drive after programming");
    txIrIn = 0; tick(1); expect5(0,0,1,0,1, "R7 IR off");

    // program SIR
    sdIn = 1; tick(2);
    sdIn = 0; tick(1); expect5(0,0,0,0,1, "R3 fall latches SIR");

    // longest programming pulse
    sdIn = 1; txIrIn = 1; tick(SHUT - 1); expect5(0,0,0,0,1, "R4 pulse below threshold keeps rx");
    sdIn = 0; tick(1); expect5(0,0,1,0,1, "R4 long pulse still programs");
    txIrIn = 0; tick(1);

    // full shutdown
    sdIn = 1; tick(SHUT - 1); expect5(0,0,1,0,1, "R4 one sample before shutdown");
    tick(1); expect5(0,0,0,0,0, "R4 R5 shutdown rx off, defaults");
    txIrIn = 1; tick(2);
    sdIn = 0; tick(1); expect5(0,0,0,0,1, "R5 release captures nothing");
    tick(1); expect5(1,0,0,0,1, "R5 direct IR after release");
    txIrIn = 0; tick(1);

    // single-input RC mode
    sdIn = 1; tick(2);
    txIrIn = 1; tick(2);
    txIrIn = 0; tick(2);
    sdIn = 0; tick(1); expect5(0,0,0,1,1, "R8 RC mode selected");
    txIrIn = 1; tick(1); expect5(0,1,0,1,1, "R8 TxIR drives RC LED");
    txIrIn = 0; txRcIn = 1; tick(1); expect5(0,0,0,1,1, "R8 TxRC ignored");
    txRcIn = 0; tick(1);

    // stuck-on on RC path (driven by TxIR)
    txIrIn = 1; tick(STUCK); expect5(0,1,0,1,1, "R9 RC LED on at limit");
    tick(1); expect5(0,0,0,1,1, "R9 RC LED cut after limit");
    tick(5); expect5(0,0,0,1,1, "R9 stays cut while source high");
    txIrIn = 0; tick(1);
    txIrIn = 1; tick(1); expect5(0,1,0,1,1, "R9 re-armed after source low");
    txIrIn = 0; tick(1);

    // back to direct mode via shutdown
    sdIn = 1; tick(SHUT); expect5(0,0,0,0,0, "R5 shutdown clears RC mode");
    sdIn = 0; tick(1);

    // independent timers
    txIrIn = 1; tick(STUCK); expect5(1,0,0,0,1, "R9 IR LED on at limit");
    tick(1); expect5(0,0,0,0,1, "R9 IR LED cut");
    txRcIn = 1; tick(1); expect5(0,1,0,0,1, "R10 RC path unaffected by IR timeout");
    txRcIn = 0; txIrIn = 0; tick(1); expect5(0,0,0,0,1, "R10 both idle");

    tick(2);
    wait (sbQ.size() == 0);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule